// File: doc/BRIEF.md
# Task-to-Processor Priority Mapper

This block sits next to a hardware task scheduler in a multiprocessor system. Each processor reports the priority of the task it is running and whether it is busy. From these the block computes one absolute priority for each processor: the rank of that processor's running task among the tasks running on all processors. Bus arbitration can then follow the urgency of the work being done, not a fixed ordering of processors.

The ranking is a permutation of 0 to NUM_CPU-1, so no two processors ever share a priority. It is published on a dedicated priority bus to the arbiter, apart from the shared system bus. Each time an input changes, the block registers the new ranking and raises a one-cycle update strobe. The processor count is a parameter and defaults to three. The task-priority width is also a parameter.

Top module: `prio_mapper`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `cpu_prio_o[i*PW +: PW] = i` for every processor i, and `prio_upd_o` becomes 0. PW is $clog2(NUM_CPU), with a minimum of 1.
- R2: Processor i's task priority is `task_prio_i[i*TPRIO_W +: TPRIO_W]`, and a smaller value is more urgent. Its output priority is the number of other processors whose task beats it. Processor priority 0 therefore belongs to the most urgent running task.
- R3: A processor with `task_valid_i[i]` low is idle. Every idle processor ranks below every busy processor.
- R4: Two busy processors with equal task priority are ordered by index, and the lower index gets the smaller processor priority. Idle processors are ordered among themselves by index alone, and their priority fields have no effect on any output priority.
- R5: The outputs are always a one-to-one mapping. Each value from 0 to NUM_CPU-1 appears exactly once.
- R6: The outputs present the ranking of the inputs sampled at the previous rising edge, one register stage.
- R7: `prio_upd_o` is high for the cycle after any edge at which the inputs differ from those at the edge before. It is also high after the first edge that follows reset.
- R8: When the inputs are unchanged from one edge to the next and reset was not just released, `prio_upd_o` is low and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| task_prio_i | input | NUM_CPU*TPRIO_W | Priority of the task running on each processor |
| task_valid_i | input | NUM_CPU | Processor is running a task |
| cpu_prio_o | output | NUM_CPU*PW | Absolute priority of each processor, sent on the priority bus |
| prio_upd_o | output | 1 | One-cycle strobe that marks a newly published ranking |

## Verification
The bench builds the block with three processors and 2-bit task priorities. That makes the input space 512 combinations of priorities and busy bits, and the bench drives every one of them. The sweep covers all tie patterns, all mixes of idle and busy processors, and idle processors carrying arbitrary priority values. After each combination the bench holds the inputs for one more cycle to check that the strobe drops and the outputs stay unchanged.

// File: rtl/prio_mapper_pkg.sv
package prio_mapper_pkg;
  // width of an index over n processors, never below one bit
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_rank_cell.sv
module prio_rank_cell #(
  parameter int NUM_CPU = 3,
  parameter int TPRIO_W = 4,
  parameter int IDX     = 0,
  localparam int PW     = prio_mapper_pkg::idx_width(NUM_CPU)
) (
  input  logic [NUM_CPU*TPRIO_W-1:0] prio_flat,
  input  logic [NUM_CPU-1:0]         valid,
  output logic [PW-1:0]              rank
);
  logic [TPRIO_W-1:0] own_p;
  logic               own_v;
  logic [NUM_CPU-1:0] beats;

  assign own_p = prio_flat[IDX*TPRIO_W +: TPRIO_W];
  assign own_v = valid[IDX];

  // beats[j]: processor j holds a better position than this one
  always_comb begin
    for (int j = 0; j < NUM_CPU; j++) begin
      logic [TPRIO_W-1:0] pj;
      logic               vj;
      pj = prio_flat[j*TPRIO_W +: TPRIO_W];
      vj = valid[j];
      if (j == IDX) begin
        beats[j] = 1'b0;
      end else if (vj && !own_v) begin
        beats[j] = 1'b1;
      end else if (!vj && own_v) begin
        beats[j] = 1'b0;
      end else if (vj && own_v) begin
        beats[j] = (pj < own_p) || ((pj == own_p) && (j < IDX));
      end else begin
        beats[j] = (j < IDX);
      end
    end
  end

  always_comb begin
    rank = '0;
    for (int j = 0; j < NUM_CPU; j++) begin
      if (beats[j]) rank = rank + PW'(1);
    end
  end
endmodule

// File: rtl/prio_change_det.sv
module prio_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data,
  output logic         changed
);
  logic [W-1:0] last_q;
  logic         after_rst_q;

  // keeps tracking during reset so a held input is not seen as new
  always_ff @(posedge clk) begin
    last_q <= data;
    if (rst) after_rst_q <= 1'b1;
    else     after_rst_q <= 1'b0;
  end

  assign changed = (data != last_q) || after_rst_q;
endmodule

// File: rtl/prio_mapper.sv
module prio_mapper #(
  parameter int NUM_CPU = 3,
  parameter int TPRIO_W = 4,
  localparam int PW     = prio_mapper_pkg::idx_width(NUM_CPU),
  localparam int IN_W   = NUM_CPU * TPRIO_W + NUM_CPU
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CPU*TPRIO_W-1:0] task_prio_i,
  input  logic [NUM_CPU-1:0]        task_valid_i,
  output logic [NUM_CPU*PW-1:0]     cpu_prio_o,
  output logic                      prio_upd_o
);
  logic [NUM_CPU*PW-1:0] rank_next;
  logic                  inp_changed;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_rank
    prio_rank_cell #(
      .NUM_CPU (NUM_CPU),
      .TPRIO_W (TPRIO_W),
      .IDX     (g)
    ) u_cell (
      .prio_flat (task_prio_i),
      .valid     (task_valid_i),
      .rank      (rank_next[g*PW +: PW])
    );
  end

  prio_change_det #(.W(IN_W)) u_chg (
    .clk     (clk),
    .rst     (rst),
    .data    ({task_valid_i, task_prio_i}),
    .changed (inp_changed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CPU; i++) cpu_prio_o[i*PW +: PW] <= PW'(i);
      prio_upd_o <= 1'b0;
    end else begin
      cpu_prio_o <= rank_next;
      prio_upd_o <= inp_changed;
    end
  end
endmodule

// File: rtl/prio_mapper_chk.sv
module prio_mapper_chk #(
  parameter int NUM_CPU = 3,
  parameter int TPRIO_W = 4,
  localparam int PW     = prio_mapper_pkg::idx_width(NUM_CPU)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CPU*TPRIO_W-1:0] task_prio_i,
  input logic [NUM_CPU-1:0]        task_valid_i,
  input logic [NUM_CPU*PW-1:0]     cpu_prio_o,
  input logic                      prio_upd_o
);
  logic [NUM_CPU-1:0] seen_mask;
  logic [NUM_CPU-1:0] valid_q;
  logic               live_q;

  always_comb begin
    seen_mask = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (int'(cpu_prio_o[i*PW +: PW]) < NUM_CPU)
        seen_mask[cpu_prio_o[i*PW +: PW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    valid_q <= task_valid_i;
    live_q  <= !rst;
  end

  // R5
  unique_prio_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (&seen_mask));

  // R1
  reset_ident_chk: assert property (@(posedge clk)
    rst |=> (!prio_upd_o && cpu_prio_o[PW-1:0] == '0));

  // R7
  change_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ({task_valid_i, task_prio_i} != $past({task_valid_i, task_prio_i})) |=> prio_upd_o);

  // R8
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $stable({task_valid_i, task_prio_i})) |=> (!prio_upd_o && $stable(cpu_prio_o)));

  // R3
  for (genvar a = 0; a < NUM_CPU; a++) begin : g_a
    for (genvar b = 0; b < NUM_CPU; b++) begin : g_b
      if (a != b) begin : g_pair
        idle_below_chk: assert property (@(posedge clk) disable iff (rst)
          (live_q && valid_q[a] && !valid_q[b]) |->
            (cpu_prio_o[a*PW +: PW] < cpu_prio_o[b*PW +: PW]));
      end
    end
  end
endmodule

bind prio_mapper prio_mapper_chk #(
  .NUM_CPU (NUM_CPU),
  .TPRIO_W (TPRIO_W)
) u_prio_mapper_chk (
  .clk          (clk),
  .rst          (rst),
  .task_prio_i  (task_prio_i),
  .task_valid_i (task_valid_i),
  .cpu_prio_o   (cpu_prio_o),
  .prio_upd_o   (prio_upd_o)
);

// File: tb/prio_mapper_bench.sv
module prio_mapper_bench;
  localparam int N  = 3;
  localparam int TW = 2;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*TW-1:0] tp = '0;
  logic [N-1:0]  tv = '0;
  logic [N*PW-1:0] cp;
  logic          upd;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  prio_mapper #(.NUM_CPU(N), .TPRIO_W(TW)) u_prio_mapper (
    .clk (clk), .rst (rst), .task_prio_i (tp), .task_valid_i (tv),
    .cpu_prio_o (cp), .prio_upd_o (upd)
  );

  // expected rank of processor i: count processors placed ahead of it
  function automatic logic [N*PW-1:0] model(logic [N*TW-1:0] p, logic [N-1:0] v);
    logic [N*PW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      int ahead;
      ahead = 0;
      for (int j = 0; j < N; j++) begin
        if (j == i) continue;
        if (v[j] != v[i]) ahead += v[j] ? 1 : 0;                    // R3
        else if (!v[i]) ahead += (j < i) ? 1 : 0;                    // R4 idle
        else if (p[j*TW +: TW] != p[i*TW +: TW])
          ahead += (p[j*TW +: TW] < p[i*TW +: TW]) ? 1 : 0;          // R2
        else ahead += (j < i) ? 1 : 0;                               // R4 tie
      end
      r[i*PW +: PW] = PW'(ahead);
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    tp = 6'h1B; tv = 3'b101;
    repeat (3) @(negedge clk);
    // R1: identity while in reset
    check("R1 prio", 32'(cp), 32'(6'b10_01_00));
    check("R1 upd", 32'(upd), 32'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 first edge after reset", 32'(upd), 32'd1);
    check("R6 rank after reset", 32'(cp), 32'(model(tp, tv)));
    @(posedge clk); @(negedge clk);
    check("R8 upd low", 32'(upd), 32'd0);
    check("R8 hold", 32'(cp), 32'(model(tp, tv)));
    for (int code = 0; code < 512; code++) begin
      logic [N*PW-1:0] exp;
      logic [8:0] c;
      c  = 9'(code);
      tv = c[8:6];
      tp = c[5:0];
      exp = model(tp, tv);
      @(posedge clk); @(negedge clk);
      check("R2 R6 ranking", 32'(cp), 32'(exp));
      check("R7 pulse", 32'(upd), 32'd1);
      @(posedge clk); @(negedge clk);
      check("R8 upd low", 32'(upd), 32'd0);
      check("R8 hold", 32'(cp), 32'(exp));
      // R5: outputs form a permutation
      begin
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) if (int'(cp[i*PW +: PW]) < N) m[cp[i*PW +: PW]] = 1'b1;
        check("R5 unique", 32'(m), 32'(3'b111));
      end
    end
    // R1: reset in mid-run restores identity
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 prio mid-run", 32'(cp), 32'(6'b10_01_00));
    check("R1 upd mid-run", 32'(upd), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule